// File: doc/BRIEF.md
# CAN Node Fault Confinement Counter

This block keeps the error bookkeeping of a CAN 2.0B node. It holds the transmit error count and the receive error count. From them it derives the node's standing: error active, error passive or bus off. The protocol engine does not pass it bits. It passes one-cycle event pulses instead, one for each error, each success and each bus-idle run of eleven recessive bits. The block turns these pulses into counter updates, a state code, a warning flag and two interrupt pulses. All outputs are registered, so an event presented before a clock edge is visible on the outputs just after that edge.

Once the transmit count passes its upper bound, the block enters bus off. The transmit counter is then reloaded with the number of bus-idle runs still needed for recovery, and it counts down as those runs arrive. While recovery is in progress the receive counter and the warning flag are held. This keeps a falling count from raising a warning interrupt early. Controller reset mode freezes both counters and also pauses recovery. Listen-only mode freezes both counters outside bus off.

The warning threshold is an input, and the integrator normally ties it to 96. The engine qualifies a transmit error with `arb_stuff` when the error was a stuff error during arbitration. A separate pulse, `tx_flag_err`, reports bit errors inside an error or overload flag and dominant-bit runs that are too long after a flag. Those always cost the transmitter.

Top module: `can_fault_confine`

## Requirements
- R1: During and just after a synchronous reset, both counters read 0, `node_state` is 0 (error active), and `err_warn`, `irq_warn` and `irq_state` are 0.
- R2: A `tx_err` pulse adds 8 to the transmit count. When `arb_stuff` is high in the same cycle, that pulse adds nothing.
- R3: A `tx_flag_err` pulse adds 8 to the transmit count whether or not `arb_stuff` is high. It adds on top of any `tx_err` step in the same cycle.
- R4: `rx_err` adds 1 and `rx_flag_err` adds 8 to the receive count, and the two add together in the same cycle. The receive count saturates at 255.
- R5: `tx_ok` lowers the transmit count by 1 and `rx_ok` lowers the receive count by 1, each stopping at 0. A decrement applies only when its counter takes no increment in that cycle.
- R6: `node_state` uses the codes 0 for error active, 1 for error passive and 2 for bus off. Outside bus off it reads 1 in the cycle after either count reaches 128 or more, and 0 otherwise.
- R7: When an increment would take the transmit count above 255, `node_state` becomes 2 and the transmit count is loaded with 128. In bus off, each `bus_free` pulse lowers it by 1. The pulse that brings it to 0 returns the node to state 0 with both counts at 0.
- R8: The receive count does not change during bus off, except for the clear at recovery. `reset_mode` freezes both counts and pauses recovery. `listen_only` freezes both counts outside bus off.
- R9: `err_warn` is 1 when either count is at or above `warn_limit`, and it follows the counts in the same cycle. In bus off it holds the value it had on entry.
- R10: `irq_warn` pulses for one cycle whenever `err_warn` changes, and never while `node_state` is 2. `irq_state` pulses for one cycle whenever `node_state` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode | input | 1 | Controller reset mode: counters and recovery frozen |
| listen_only | input | 1 | Listen-only mode: counters frozen outside bus off |
| warn_limit | input | 8 | Warning threshold for both counts |
| tx_err | input | 1 | Transmitter detected an error and sends an error flag |
| arb_stuff | input | 1 | Qualifies tx_err as a stuff error during arbitration |
| tx_flag_err | input | 1 | Bit error in own error/overload flag, or too many dominant bits after it |
| tx_ok | input | 1 | Frame transmitted successfully |
| rx_err | input | 1 | Receiver detected an error |
| rx_flag_err | input | 1 | Receiver-side severe error (dominant after own flag) |
| rx_ok | input | 1 | Frame received successfully |
| bus_free | input | 1 | Eleven consecutive recessive bits observed |
| tec | output | 8 | Transmit error count, or remaining recovery runs in bus off |
| rec | output | 8 | Receive error count |
| node_state | output | 2 | 0 active, 1 passive, 2 bus off |
| err_warn | output | 1 | Warning status |
| irq_warn | output | 1 | One-cycle pulse on warning status change |
| irq_state | output | 1 | One-cycle pulse on node state change |

## Verification
The bench walks the transmit count to exactly 248 and then over 255. A design that compared against the wrong bound would either leave bus off late or reload the wrong recovery count. It counts recovery down to 1 and then to 0 while checking that the warning flag and its interrupt stay still. A design that let the warning follow the falling count would pulse `irq_warn` early, and this bench would catch that. It pairs `tx_err` with `arb_stuff`, with and without `tx_flag_err`. A design that let the qualifier suppress flag errors, or ignored it altogether, would show a transmit count off by 8. It also drives error pulses under reset mode and listen-only mode, and `bus_free` pulses under reset mode, to catch a design that forgets a freeze.

// File: rtl/canfc_pkg.sv
package canfc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } cf_state_e;
endpackage

// File: rtl/canfc_tec.sv
module canfc_tec #(
  parameter int TX_STEP      = 8,
  parameter int BUSOFF_TH    = 255,
  parameter int RECOV_EVENTS = 128,
  parameter int TEC_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             hold_recov,
  input  logic             in_bus_off,
  input  logic             tx_err,
  input  logic             arb_stuff,
  input  logic             flag_err,
  input  logic             tx_ok,
  input  logic             bus_free,
  output logic [TEC_W-1:0] tec_q,
  output logic [TEC_W-1:0] tec_nxt,
  output logic             enter_bus_off,
  output logic             recov_done
);
  localparam int SUM_W = TEC_W + 2;

  logic [SUM_W-1:0] inc;
  logic [SUM_W-1:0] sum;

  always_comb begin
    inc = '0;
    if (tx_err && !arb_stuff) inc = inc + SUM_W'(TX_STEP);
    if (flag_err)             inc = inc + SUM_W'(TX_STEP);
    sum           = {2'b00, tec_q} + inc;
    tec_nxt       = tec_q;
    enter_bus_off = 1'b0;
    recov_done    = 1'b0;
    if (in_bus_off) begin
      if (!hold_recov && bus_free) begin
        tec_nxt = tec_q - 1'b1;
        if (tec_q == TEC_W'(1)) recov_done = 1'b1;
      end
    end else if (!freeze) begin
      if (inc != '0) begin
        if (int'(sum) > BUSOFF_TH) begin
          enter_bus_off = 1'b1;
          tec_nxt       = TEC_W'(RECOV_EVENTS);
        end else begin
          tec_nxt = sum[TEC_W-1:0];
        end
      end else if (tx_ok && tec_q != '0) begin
        tec_nxt = tec_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tec_q <= '0;
    else     tec_q <= tec_nxt;
  end

  // R8
  rmode_tec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold_recov |=> tec_q == $past(tec_q));

  // R2
  tec_step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !in_bus_off |=> int'(tec_q) <= int'($past(tec_q)) + 2 * TX_STEP);

  // R3
  flag_bump_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_err && !freeze && !in_bus_off) |=> tec_q != $past(tec_q));
endmodule

// File: rtl/canfc_rec.sv
module canfc_rec #(
  parameter int RX_FLAG_STEP = 8,
  parameter int REC_MAX      = 255,
  parameter int REC_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             in_bus_off,
  input  logic             clear,
  input  logic             rx_err,
  input  logic             rx_flag_err,
  input  logic             rx_ok,
  output logic [REC_W-1:0] rec_q,
  output logic [REC_W-1:0] rec_nxt
);
  localparam int SUM_W = REC_W + 2;

  logic [SUM_W-1:0] inc;
  logic [SUM_W-1:0] sum;

  always_comb begin
    inc = '0;
    if (rx_err)      inc = inc + SUM_W'(1);
    if (rx_flag_err) inc = inc + SUM_W'(RX_FLAG_STEP);
    sum     = {2'b00, rec_q} + inc;
    rec_nxt = rec_q;
    if (clear) begin
      rec_nxt = '0;
    end else if (!in_bus_off && !freeze) begin
      if (inc != '0) begin
        if (int'(sum) > REC_MAX) rec_nxt = REC_W'(REC_MAX);
        else                     rec_nxt = sum[REC_W-1:0];
      end else if (rx_ok && rec_q != '0) begin
        rec_nxt = rec_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= '0;
    else     rec_q <= rec_nxt;
  end

  // R8
  busoff_rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_bus_off && !clear) |=> $stable(rec_q));

  // R5
  rec_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ok && !rx_err && !rx_flag_err && !freeze && !in_bus_off && rec_q != '0)
      |=> int'(rec_q) == int'($past(rec_q)) - 1);
endmodule

// File: rtl/canfc_status.sv
module canfc_status
  import canfc_pkg::*;
#(
  parameter int PASSIVE_TH = 128,
  parameter int TEC_W      = 8,
  parameter int REC_W      = 8,
  parameter int LIM_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TEC_W-1:0] tec_q,
  input  logic [REC_W-1:0] rec_q,
  input  logic [TEC_W-1:0] tec_nxt,
  input  logic [REC_W-1:0] rec_nxt,
  input  logic             enter_bus_off,
  input  logic             recov_done,
  input  logic [LIM_W-1:0] warn_limit,
  output cf_state_e        state_q,
  output logic             warn_q,
  output logic             irq_warn,
  output logic             irq_state
);
  cf_state_e state_n;
  logic      warn_n;

  always_comb begin
    if (enter_bus_off)            state_n = ST_BUSOFF;
    else if (recov_done)          state_n = ST_ACTIVE;
    else if (state_q == ST_BUSOFF) state_n = ST_BUSOFF;
    else if (int'(tec_nxt) >= PASSIVE_TH || int'(rec_nxt) >= PASSIVE_TH)
                                  state_n = ST_PASSIVE;
    else                          state_n = ST_ACTIVE;

    if (state_n == ST_BUSOFF) warn_n = warn_q;
    else warn_n = (int'(tec_nxt) >= int'(warn_limit)) ||
                  (int'(rec_nxt) >= int'(warn_limit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACTIVE;
      warn_q    <= 1'b0;
      irq_warn  <= 1'b0;
      irq_state <= 1'b0;
    end else begin
      state_q   <= state_n;
      warn_q    <= warn_n;
      irq_warn  <= (warn_n != warn_q);
      irq_state <= (state_n != state_q);
    end
  end

  // R10
  no_warn_irq_busoff_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_BUSOFF |-> !irq_warn);

  // R9
  warn_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSOFF && $past(state_q) == ST_BUSOFF) |-> $stable(warn_q));

  // R6
  passive_level_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_PASSIVE |-> (int'(tec_q) >= PASSIVE_TH || int'(rec_q) >= PASSIVE_TH));

  // R10
  warn_irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    irq_warn |-> warn_q != $past(warn_q));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import canfc_pkg::*;
#(
  parameter int PASSIVE_TH   = 128,
  parameter int BUSOFF_TH    = 255,
  parameter int RECOV_EVENTS = 128,
  parameter int TX_STEP      = 8,
  parameter int RX_FLAG_STEP = 8,
  parameter int REC_MAX      = 255,
  parameter int LIM_W        = 8,
  localparam int TEC_W       = $clog2(BUSOFF_TH + 1),
  localparam int REC_W       = $clog2(REC_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reset_mode,
  input  logic             listen_only,
  input  logic [LIM_W-1:0] warn_limit,
  input  logic             tx_err,
  input  logic             arb_stuff,
  input  logic             tx_flag_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_flag_err,
  input  logic             rx_ok,
  input  logic             bus_free,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic [1:0]       node_state,
  output logic             err_warn,
  output logic             irq_warn,
  output logic             irq_state
);
  logic             freeze;
  logic             in_bus_off;
  logic [TEC_W-1:0] tec_nxt;
  logic [REC_W-1:0] rec_nxt;
  logic             enter_bus_off;
  logic             recov_done;
  cf_state_e        state_q;

  assign freeze     = reset_mode | listen_only;
  assign in_bus_off = (state_q == ST_BUSOFF);
  assign node_state = state_q;

  canfc_tec #(
    .TX_STEP(TX_STEP), .BUSOFF_TH(BUSOFF_TH),
    .RECOV_EVENTS(RECOV_EVENTS), .TEC_W(TEC_W)
  ) u_tec (
    .clk(clk), .rst(rst), .freeze(freeze), .hold_recov(reset_mode),
    .in_bus_off(in_bus_off), .tx_err(tx_err), .arb_stuff(arb_stuff),
    .flag_err(tx_flag_err), .tx_ok(tx_ok), .bus_free(bus_free),
    .tec_q(tec), .tec_nxt(tec_nxt), .enter_bus_off(enter_bus_off),
    .recov_done(recov_done)
  );

  canfc_rec #(
    .RX_FLAG_STEP(RX_FLAG_STEP), .REC_MAX(REC_MAX), .REC_W(REC_W)
  ) u_rec (
    .clk(clk), .rst(rst), .freeze(freeze), .in_bus_off(in_bus_off),
    .clear(recov_done), .rx_err(rx_err), .rx_flag_err(rx_flag_err),
    .rx_ok(rx_ok), .rec_q(rec), .rec_nxt(rec_nxt)
  );

  canfc_status #(
    .PASSIVE_TH(PASSIVE_TH), .TEC_W(TEC_W), .REC_W(REC_W), .LIM_W(LIM_W)
  ) u_status (
    .clk(clk), .rst(rst), .tec_q(tec), .rec_q(rec), .tec_nxt(tec_nxt),
    .rec_nxt(rec_nxt), .enter_bus_off(enter_bus_off), .recov_done(recov_done),
    .warn_limit(warn_limit), .state_q(state_q), .warn_q(err_warn),
    .irq_warn(irq_warn), .irq_state(irq_state)
  );
endmodule

// File: tb/sim_can_fault_confine.sv
`timescale 1ns/1ps
module sim_can_fault_confine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reset_mode = 1'b0, listen_only = 1'b0;
  logic [7:0] warn_limit = 8'd96;
  logic       tx_err = 1'b0, arb_stuff = 1'b0, tx_flag_err = 1'b0, tx_ok = 1'b0;
  logic       rx_err = 1'b0, rx_flag_err = 1'b0, rx_ok = 1'b0, bus_free = 1'b0;
  logic [7:0] tec, rec;
  logic [1:0] node_state;
  logic       err_warn, irq_warn, irq_state;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  can_fault_confine u0 (
    .clk(clk), .rst(rst), .reset_mode(reset_mode), .listen_only(listen_only),
    .warn_limit(warn_limit), .tx_err(tx_err), .arb_stuff(arb_stuff),
    .tx_flag_err(tx_flag_err), .tx_ok(tx_ok), .rx_err(rx_err),
    .rx_flag_err(rx_flag_err), .rx_ok(rx_ok), .bus_free(bus_free),
    .tec(tec), .rec(rec), .node_state(node_state), .err_warn(err_warn),
    .irq_warn(irq_warn), .irq_state(irq_state)
  );

  // Behavioural reference model
  int m_tec = 0, m_rec = 0, m_st = 0, m_warn = 0, m_iw = 0, m_is = 0;
  bit cmp_on = 1'b0;

  always @(posedge clk) begin
    int nt, nr, ns, nw, ti, ri;
    bit done;
    if (rst) begin
      m_tec = 0; m_rec = 0; m_st = 0; m_warn = 0; m_iw = 0; m_is = 0;
      cmp_on = 1'b1;
    end else begin
      nt = m_tec; nr = m_rec; ns = m_st; done = 1'b0;
      if (m_st == 2) begin
        if (!reset_mode && bus_free) begin
          nt = m_tec - 1;
          if (nt == 0) begin done = 1'b1; nr = 0; ns = 0; end
        end
      end else if (!reset_mode && !listen_only) begin
        ti = ((tx_err && !arb_stuff) ? 8 : 0) + (tx_flag_err ? 8 : 0);
        if (ti > 0) nt = nt + ti;
        else if (tx_ok && nt > 0) nt = nt - 1;
        ri = (rx_err ? 1 : 0) + (rx_flag_err ? 8 : 0);
        if (ri > 0) nr = (nr + ri > 255) ? 255 : nr + ri;
        else if (rx_ok && nr > 0) nr = nr - 1;
        if (nt > 255) begin ns = 2; nt = 128; end
        else ns = (nt >= 128 || nr >= 128) ? 1 : 0;
      end
      if (ns == 2 && !done) nw = m_warn;
      else nw = (nt >= warn_limit || nr >= warn_limit) ? 1 : 0;
      m_iw = (nw != m_warn) ? 1 : 0;
      m_is = (ns != m_st) ? 1 : 0;
      m_tec = nt; m_rec = nr; m_st = ns; m_warn = nw;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2/R3/R5/R7 tec", int'(tec), m_tec);
      chk("R4/R5/R8 rec", int'(rec), m_rec);
      chk("R6/R7 state", int'(node_state), m_st);
      chk("R9 warn", int'(err_warn), m_warn);
      chk("R10 irq_warn", int'(irq_warn), m_iw);
      chk("R10 irq_state", int'(irq_state), m_is);
    end
  end

  task automatic step();
    @(negedge clk);
    tx_err = 0; arb_stuff = 0; tx_flag_err = 0; tx_ok = 0;
    rx_err = 0; rx_flag_err = 0; rx_ok = 0; bus_free = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic rand_run(input int n, input int p_err, input int p_ok, input int p_mode);
    for (int i = 0; i < n; i++) begin
      tx_err      = ($urandom_range(99) < p_err);
      arb_stuff   = ($urandom_range(99) < 30);
      tx_flag_err = ($urandom_range(99) < p_err / 3);
      tx_ok       = ($urandom_range(99) < p_ok);
      rx_err      = ($urandom_range(99) < p_err);
      rx_flag_err = ($urandom_range(99) < p_err / 3);
      rx_ok       = ($urandom_range(99) < p_ok);
      bus_free    = ($urandom_range(99) < 60);
      reset_mode  = ($urandom_range(99) < p_mode);
      listen_only = ($urandom_range(99) < p_mode);
      step();
    end
    reset_mode = 0; listen_only = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset values
    chk("R1 tec", int'(tec), 0); chk("R1 rec", int'(rec), 0);
    chk("R1 state", int'(node_state), 0); chk("R1 warn", int'(err_warn), 0);
    rst = 1'b0;
    // R2 plain and exempt transmit errors
    tx_err = 1; step(); chk("R2 tx_err", int'(tec), 8);
    tx_err = 1; arb_stuff = 1; step(); chk("R2 arb stuff exempt", int'(tec), 8);
    // R3 flag error counts despite qualifier
    tx_err = 1; arb_stuff = 1; tx_flag_err = 1; step(); chk("R3 flag err", int'(tec), 16);
    tx_err = 1; tx_flag_err = 1; step(); chk("R3 both", int'(tec), 32);
    // R5 decrement, blocked by simultaneous increment
    tx_ok = 1; step(); chk("R5 tx_ok", int'(tec), 31);
    tx_ok = 1; tx_err = 1; step(); chk("R5 inc wins", int'(tec), 39);
    // R4 receive counting
    rx_err = 1; rx_flag_err = 1; step(); chk("R4 rx sum", int'(rec), 9);
    rx_ok = 1; step(); chk("R5 rx_ok", int'(rec), 8);
    for (int i = 0; i < 40; i++) begin rx_flag_err = 1; step(); end
    chk("R4 saturate", int'(rec), 255);
    chk("R6 passive by rec", int'(node_state), 1);
    for (int i = 0; i < 300; i++) begin rx_ok = 1; tx_ok = 1; step(); end
    chk("R5 floor tec", int'(tec), 0); chk("R5 floor rec", int'(rec), 0);
    chk("R6 active again", int'(node_state), 0);
    // R6 passive on reaching 128 from 120
    for (int i = 0; i < 15; i++) begin tx_err = 1; step(); end
    chk("R6 at 120", int'(node_state), 0);
    tx_err = 1; step();
    chk("R6 tec 128", int'(tec), 128); chk("R6 passive", int'(node_state), 1);
    // R8 freezes
    reset_mode = 1; tx_err = 1; rx_err = 1; step();
    chk("R8 rmode tec", int'(tec), 128); chk("R8 rmode rec", int'(rec), 0);
    reset_mode = 0; listen_only = 1; tx_err = 1; rx_err = 1; tx_ok = 1; step();
    chk("R8 lonly tec", int'(tec), 128); chk("R8 lonly rec", int'(rec), 0);
    listen_only = 0;
    // R7 bus off and recovery
    do_reset();
    for (int i = 0; i < 5; i++) begin rx_err = 1; step(); end
    for (int i = 0; i < 31; i++) begin tx_err = 1; step(); end
    chk("R7 tec 248", int'(tec), 248); chk("R9 warn on", int'(err_warn), 1);
    tx_err = 1; step();
    chk("R7 busoff", int'(node_state), 2); chk("R7 reload", int'(tec), 128);
    rx_err = 1; rx_flag_err = 1; tx_err = 1; step();
    chk("R8 rec frozen busoff", int'(rec), 5); chk("R7 tec busoff", int'(tec), 128);
    reset_mode = 1;
    for (int i = 0; i < 10; i++) begin bus_free = 1; step(); end
    chk("R8 recovery paused", int'(tec), 128);
    reset_mode = 0;
    for (int i = 0; i < 127; i++) begin bus_free = 1; step(); end
    chk("R7 remaining", int'(tec), 1); chk("R7 still off", int'(node_state), 2);
    chk("R9 warn held", int'(err_warn), 1); chk("R10 no irq", int'(irq_warn), 0);
    bus_free = 1; step();
    chk("R7 done state", int'(node_state), 0); chk("R7 done tec", int'(tec), 0);
    chk("R7 done rec", int'(rec), 0); chk("R10 irq at done", int'(irq_warn), 1);
    chk("R10 irq state", int'(irq_state), 1);
    step(); chk("R10 pulse width", int'(irq_warn), 0);
    // R9 programmable limit
    warn_limit = 8'd4; rx_err = 1; step(); step();
    chk("R9 below limit", int'(err_warn), 0);
    for (int i = 0; i < 3; i++) begin rx_err = 1; step(); end
    chk("R9 at limit", int'(err_warn), 1);
    // randomized patterns
    warn_limit = 8'd96; rand_run(3000, 10, 40, 5);
    warn_limit = 8'd40; rand_run(3000, 35, 10, 10);
    warn_limit = 8'd0;  rand_run(2000, 50, 5, 2);
    warn_limit = 8'd200; rand_run(3000, 20, 20, 20);
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule